// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Stage

This block sits between software and the bit-level engine of a two-wire serial controller. Software writes bytes one at a time into a single-entry holding register. Whenever the byte-wide shift register is free, the held byte moves into it. The shift register then offers its bits, most significant first, to the bit engine through a request/done handshake. Status levels report whether the holding register has room and whether transmission has run dry. Sticky interrupt flags record the same events and a rejected write, and software clears them with a write-one-to-clear vector.

A clear command empties the path. A byte that the engine has already started shifting is always finished. Bus timing, protocol sequencing and register decoding belong to the surrounding controller.

Top module: `serial_tx_stage`

## Requirements
- R1: When the shift register is empty, or is finishing its last bit in the same cycle, a byte in the holding register moves into it on the next edge. The shifted byte stays until all 8 bits are done, so back-to-back bytes leave no gap.
- R2: `bit_req_o` is high while the shift register holds a byte and `bit_o` shows its current bit, most significant bit first. Each `bit_done_i` pulse advances one bit. `byte_done_o` is high in the cycle of the eighth `bit_done_i`.
- R3: `room_o` is 1 and interrupt bit 0 is set on each move from holding register to shift register. `room_o` clears on the edge that accepts a software write.
- R4: When a byte finishes and the holding register is empty, `idle_o` and interrupt bit 1 are set. `idle_o` clears when a write is accepted. Interrupt bit 1 stays set until software clears it.
- R5: A write while the holding register is full is discarded, the held byte is kept, and interrupt bit 2 is set.
- R6: The clear command empties the holding register (`room_o` reads 1) and drops a shift register byte that has no bit done yet. A byte with at least one bit done is completed, and no byte is reloaded after it.
- R7: A write in the same cycle as the clear command is discarded without setting interrupt bit 2.
- R8: Interrupt flags `irq_o[2:0]` (0 room, 1 complete, 2 overflow) are cleared by 1 bits in `irq_clr_i`. A set event in the same cycle wins over the clear.
- R9: After reset the buffer and shift register are empty, `bit_req_o` is 0, `room_o` is 1, `idle_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe for the holding register |
| wr_data_i | input | 8 | Byte to write |
| clear_i | input | 1 | Clear command |
| irq_clr_i | input | 3 | Write-one-to-clear vector for interrupt flags |
| bit_done_i | input | 1 | Bit engine finished the current bit |
| bit_req_o | output | 1 | Shift register holds a byte to send |
| bit_o | output | 1 | Current bit, MSB first |
| byte_done_o | output | 1 | Eighth bit completed this cycle |
| room_o | output | 1 | Holding register can take a byte |
| idle_o | output | 1 | Transmitter ran out of data |
| irq_o | output | 3 | Sticky interrupt flags |

## Verification
The bench stalls the bit engine to fill both stages, then writes again. A design that overwrites the held byte would send the third byte instead of the second. It clears interrupt bits in the same cycle as a new set event; a clear-wins design would lose the overflow flag. It issues the clear command before any bit and again mid-byte. A design that aborts in-flight bytes would truncate the scoreboard sequence, and one that keeps the unstarted byte, or reloads the dropped holding byte, would emit bytes the scoreboard never expected. A back-to-back pair checks that reload happens on the finishing edge and that the completion flag does not rise between the two bytes.

// File: rtl/tx_stage_pkg.sv
package tx_stage_pkg;
  localparam int unsigned IRQ_W    = 3;
  localparam int unsigned IRQ_ROOM = 0;
  localparam int unsigned IRQ_IDLE = 1;
  localparam int unsigned IRQ_OVF  = 2;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clear_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              accept_o,
  output logic              ovf_o
);
  assign accept_o = wr_en_i & ~clear_i & ~valid_o;
  assign ovf_o    = wr_en_i & ~clear_i &  valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end else if (accept_o) begin
      valid_o <= 1'b1;
      data_o  <= wr_data_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_OVF_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> data_o == $past(data_o)); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !valid_o); // R6
endmodule

// File: rtl/tx_shift_reg.sv
module tx_shift_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              bit_done_i,
  input  logic              clear_i,
  output logic              busy_o,
  output logic              bit_o,
  output logic              finish_o,
  output logic              ready_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_flight;

  assign bit_o     = sr_q[DATA_W-1];
  assign finish_o  = busy_o & bit_done_i & (cnt_q == LAST);
  assign ready_o   = ~busy_o | finish_o;
  // a byte counts as started once any bit has been consumed
  assign in_flight = (cnt_q != '0) | bit_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      sr_q   <= load_data_i;
      cnt_q  <= '0;
    end else if (finish_o) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o && clear_i && !in_flight) begin
      busy_o <= 1'b0;
    end else if (busy_o && bit_done_i) begin
      sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_HOLD_UNTIL_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !bit_done_i && !clear_i && !load_i |=> busy_o && $stable(bit_o)); // R1
  AST_INFLIGHT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && clear_i && (cnt_q != '0) && !finish_o |=> busy_o); // R6
endmodule

// File: rtl/tx_irq_flags.sv
module tx_irq_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_i) | set_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]); // R8
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> $past(set_i[i])); // R8
  end
endmodule

// File: rtl/serial_tx_stage.sv
module serial_tx_stage
  import tx_stage_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clear_i,
  input  logic [IRQ_W-1:0]  irq_clr_i,
  input  logic              bit_done_i,
  output logic              bit_req_o,
  output logic              bit_o,
  output logic              byte_done_o,
  output logic              room_o,
  output logic              idle_o,
  output logic [IRQ_W-1:0]  irq_o
);
  logic              hb_valid, accept, ovf, take, sr_ready, finish, done_ev;
  logic [DATA_W-1:0] hb_data;
  logic [IRQ_W-1:0]  irq_set;

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .clear_i,
    .take_i(take), .valid_o(hb_valid), .data_o(hb_data),
    .accept_o(accept), .ovf_o(ovf)
  );

  assign take = hb_valid & sr_ready & ~clear_i;

  tx_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .load_i(take), .load_data_i(hb_data),
    .bit_done_i, .clear_i, .busy_o(bit_req_o), .bit_o,
    .finish_o(finish), .ready_o(sr_ready)
  );

  assign byte_done_o = finish;
  assign done_ev     = finish & (~hb_valid | clear_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      room_o <= 1'b1;
      idle_o <= 1'b0;
    end else begin
      if (take || clear_i) room_o <= 1'b1;
      else if (accept)     room_o <= 1'b0;
      if (accept)       idle_o <= 1'b0;
      else if (done_ev) idle_o <= 1'b1;
    end
  end

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_ROOM] = take;
    irq_set[IRQ_IDLE] = done_ev;
    irq_set[IRQ_OVF]  = ovf;
  end

  tx_irq_flags #(.N(IRQ_W)) u_irq (
    .clk_i, .rst_ni, .set_i(irq_set), .clr_i(irq_clr_i), .flag_o(irq_o)
  );

  AST_ROOM_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> room_o && irq_o[IRQ_ROOM]); // R3
  AST_IDLE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ev && !accept |=> idle_o); // R4
  AST_NO_REQ_AFTER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !bit_req_o |=> !bit_req_o); // R6
endmodule

// File: tb/serial_tx_stage_test.sv
`timescale 1ns/1ps
module serial_tx_stage_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       clear = 1'b0;
  logic [2:0] irq_clr = '0;
  logic       bit_done;
  logic       bit_req, bit_v, byte_done, room, idle;
  logic [2:0] irq;

  int errors = 0, checks = 0;
  bit finished = 0;
  bit eng_en = 0;
  int nb = 0;
  logic [7:0] cur = '0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  serial_tx_stage uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .clear_i(clear), .irq_clr_i(irq_clr), .bit_done_i(bit_done),
    .bit_req_o(bit_req), .bit_o(bit_v), .byte_done_o(byte_done),
    .room_o(room), .idle_o(idle), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // bit engine stub and scoreboard monitor
  initial begin
    bit_done = 1'b0;
    forever begin
      @(negedge clk);
      if (bit_done) bit_done = 1'b0;
      else if (eng_en && bit_req && rst_n) begin
        cur = {cur[6:0], bit_v};
        bit_done = 1'b1;
        nb++;
        #1;
        if (nb == 8) begin
          chk(byte_done == 1'b1, "R2 byte_done on 8th bit", byte_done, 1);
          if (exp_q.size() == 0) chk(0, "R6 unexpected byte", cur, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(cur == e, "R1/R2/R5 byte order", cur, e);
          end
          nb = 0;
        end else if (byte_done) chk(0, "R2 early byte_done", nb, 8);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  task automatic write(input logic [7:0] d, input logic [2:0] c = 3'b000);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; irq_clr = c;
    @(negedge clk);
    wr_en = 1'b0; irq_clr = '0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic w1c(input logic [2:0] c);
    @(negedge clk);
    irq_clr = c;
    @(negedge clk);
    irq_clr = '0;
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || bit_req) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(room == 1'b1, "R9 room", room, 1);
    chk(idle == 1'b0, "R9 idle", idle, 0);
    chk(irq == 3'b000, "R9 irq", irq, 0);
    chk(bit_req == 1'b0, "R9 bit_req", bit_req, 0);

    // first byte, engine stalled
    write(8'hA5); exp_q.push_back(8'hA5);
    chk(room == 1'b0, "R3 room clears on write", room, 0);
    @(negedge clk);
    chk(room == 1'b1, "R3 room after load", room, 1);
    chk(irq[0] == 1'b1, "R3 room irq", irq[0], 1);
    chk(bit_req == 1'b1, "R2 bit_req when loaded", bit_req, 1);
    chk(bit_v == 1'b1, "R2 MSB first", bit_v, 1);
    w1c(3'b001);
    chk(irq[0] == 1'b0, "R8 w1c", irq[0], 0);

    // fill buffer, then overflow with a same-cycle clear of bit 2
    write(8'h3C); exp_q.push_back(8'h3C);
    chk(room == 1'b0, "R3 room with full buffer", room, 0);
    write(8'hFF, 3'b100);
    chk(irq[2] == 1'b1, "R5/R8 overflow set wins", irq[2], 1);
    eng_en = 1;
    drain();
    chk(idle == 1'b1, "R4 idle after last byte", idle, 1);
    chk(irq[1] == 1'b1, "R4 complete irq", irq[1], 1);

    // new data clears idle, irq stays sticky
    write(8'h81); exp_q.push_back(8'h81);
    chk(idle == 1'b0, "R4 idle clears on write", idle, 0);
    chk(irq[1] == 1'b1, "R4 complete irq sticky", irq[1], 1);
    drain();

    // clear before any bit: byte dropped
    eng_en = 0;
    write(8'h42);
    @(negedge clk);
    chk(bit_req == 1'b1, "R1 loaded before clear", bit_req, 1);
    do_clear();
    chk(bit_req == 1'b0, "R6 unstarted byte dropped", bit_req, 0);
    chk(room == 1'b1, "R6 room after clear", room, 1);
    eng_en = 1;
    repeat (40) @(negedge clk);

    // clear mid-byte: in-flight byte completes, held byte dropped
    w1c(3'b111);
    write(8'hC3); exp_q.push_back(8'hC3);
    @(negedge clk);
    write(8'h99);
    while (nb < 3) @(posedge clk);
    do_clear();
    chk(bit_req == 1'b1, "R6 in-flight byte kept", bit_req, 1);
    drain();
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R6 in-flight completed", exp_q.size(), 0);
    chk(idle == 1'b1, "R6 idle after completed byte", idle, 1);
    chk(irq[1] == 1'b1, "R4 complete irq after clear", irq[1], 1);

    // clear and write in the same cycle
    eng_en = 0;
    w1c(3'b111);
    @(negedge clk);
    clear = 1'b1; wr_en = 1'b1; wr_data = 8'h55;
    @(negedge clk);
    clear = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk(bit_req == 1'b0, "R7 write discarded", bit_req, 0);
    chk(room == 1'b1, "R7 room stays", room, 1);
    chk(irq[2] == 1'b0, "R7 no overflow", irq[2], 0);
    eng_en = 1;
    repeat (40) @(negedge clk);

    // back-to-back bytes: reload on the finishing edge
    w1c(3'b111);
    write(8'h11); exp_q.push_back(8'h11);
    @(negedge clk);
    write(8'h22); exp_q.push_back(8'h22);
    while (exp_q.size() == 2) @(negedge clk);
    chk(bit_req == 1'b1, "R1 second byte loaded at once", bit_req, 1);
    chk(irq[1] == 1'b0, "R1 no complete between bytes", irq[1], 0);
    drain();
    chk(exp_q.size() == 0, "R1 all bytes sent", exp_q.size(), 0);
    chk(idle == 1'b1, "R4 idle at end", idle, 1);
    finish_run();
  end
endmodule